// File: doc/BRIEF.md
# Security-Banked Fault Status Registers

This block is a memory-mapped register slice that holds the configurable fault status word for each of two security states (secure and non-secure), together with one bus fault address register. It sits on a simple register bus with a request strobe, a write flag, an address, a byte count and a secure-access attribute. Every request gets exactly one registered response, with read data and an error flag, on the following cycle.

Byte 1 of the status word (bits [15:8], the bus fault status byte) is not kept per state. One physical copy exists, and both states see it. An input bit tells the slice whether bus faults are routed to the non-secure state. When that bit is low, a non-secure access sees the shared byte and the fault address as zero and cannot change either of them. Status writes are write-one-to-clear and may be byte, halfword or word wide. A capture port lets fault logic set status bits in a chosen bank.

The slice is sequenced by a two-state response machine. PH_IDLE means no response is pending. PH_RESP means a response is being presented. The machine has four transitions:
- idle-to-resp, on a request;
- resp-to-resp, on a back-to-back request;
- resp-to-idle, when no request arrives;
- idle-to-idle, while the bus stays quiet.

Top module: `fault_status_banks`

## Requirements
- R1: After reset, both status banks and the fault address hold zero, and rsp_valid is low.
- R2: The shared byte is a single copy: a secure read, and a non-secure read while bf_to_ns=1, both return the same bits [15:8].
- R3: A non-secure read of the status word while bf_to_ns=0 returns the non-secure bank with bits [15:8] forced to zero.
- R4: The status word sits at address 0xD28, and size gives the byte count (1, 2 or 4). For off=addr-0xD28, read data equals (word >> 8*off) masked to size bytes, with zeros above.
- R5: A status write clears every bit where (wdata << 8*off) has a 1 within the addressed bytes. It clears them in the bank of the requesting state only. Write responses carry rdata=0.
- R6: A non-secure status write while bf_to_ns=0 leaves bits [15:8] unchanged.
- R7: A secure status write that clears bits in [15:8] clears them in the shared copy. Non-secure readers then see the cleared value.
- R8: The fault address at 0xD38 reads 0 and ignores writes for a non-secure access while bf_to_ns=0. Otherwise it reads and writes its stored 32-bit value.
- R9: A fault address access with a size other than 4 returns rsp_err=1. When parameter HAS_MAIN=0, every fault address access returns rsp_err=1.
- R10: An access with an unknown address, with size not in {1,2,4}, or with off+size>4 returns rsp_err=1 and rdata=0, and changes no state.
- R11: A capture pulse ORs cap_mask into the bank chosen by cap_secure, and bits [15:8] go to the shared copy. A clear from a same-cycle write loses to the capture.
- R12: rsp_valid is high in the cycle after each request and low in the cycle after a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request strobe |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte offset of the access |
| size | input | 3 | Byte count of the access (1, 2 or 4) |
| wdata | input | 32 | Write data, right-aligned |
| secure | input | 1 | Access made by the secure state |
| bf_to_ns | input | 1 | Bus faults routed to the non-secure state |
| cap_valid | input | 1 | Fault capture strobe |
| cap_secure | input | 1 | Capture targets the secure bank |
| cap_mask | input | 32 | Status bits to set |
| rsp_valid | output | 1 | Response present |
| rdata | output | 32 | Read data, right-aligned |
| rsp_err | output | 1 | Error response |

## Verification
Every result appears one clock edge after the request or capture that caused it. Read data and the error flag are registered at the edge that samples the request. State written at that edge is visible to a read issued in the next cycle. The bench drives each request on a falling edge and samples the response on the next falling edge, half a period after the registering edge. It then checks that rsp_valid has dropped one further falling edge later. Writes and captures are judged by follow-up reads, so each effect is checked one full access after it was made.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned ADDR_W      = 12;
    localparam int unsigned LANES       = DATA_W / 8;
    localparam int unsigned SHARED_LANE = 1;
    localparam logic [ADDR_W-1:0] STATUS_ADDR = 12'hD28;
    localparam logic [ADDR_W-1:0] FADDR_ADDR  = 12'hD38;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RESP = 1'b1
    } phase_t;
endpackage

// File: rtl/fsr_decode.sv
module fsr_decode
    import fsr_pkg::*;
#(
    parameter bit HAS_MAIN = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    output logic              hit_status,
    output logic              hit_faddr,
    output logic              bad,
    output logic [1:0]        byte_off,
    output logic [DATA_W-1:0] lane_mask
);
    logic in_status;
    logic size_ok;
    logic fits;
    logic faddr_legal;
    int unsigned first_lane;
    int unsigned end_lane;

    always_comb begin
        in_status  = (addr[ADDR_W-1:2] == STATUS_ADDR[ADDR_W-1:2]);
        byte_off   = addr[1:0];
        size_ok    = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
        first_lane = 32'(byte_off);
        end_lane   = first_lane + 32'(size);
        fits       = (end_lane <= LANES);
        for (int b = 0; b < LANES; b++) begin
            lane_mask[b*8 +: 8] = ((b >= first_lane) && (b < end_lane)) ? 8'hFF : 8'h00;
        end
    end

    generate
        if (HAS_MAIN) begin : g_faddr_on
            assign faddr_legal = (addr == FADDR_ADDR) && (size == 3'd4);
        end else begin : g_faddr_off
            assign faddr_legal = 1'b0;
        end
    endgenerate

    assign hit_status = in_status && size_ok && fits;
    assign hit_faddr  = faddr_legal;
    assign bad        = !hit_status && !hit_faddr;
endmodule

// File: rtl/fsr_status_store.sv
module fsr_status_store
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic              clr_secure,
    input  logic [DATA_W-1:0] clr_mask,
    input  logic              cap_valid,
    input  logic              cap_secure,
    input  logic [DATA_W-1:0] cap_mask,
    output logic [DATA_W-1:0] bank_s,
    output logic [DATA_W-1:0] bank_ns
);
    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            if (g == SHARED_LANE) begin : g_shared
                logic [7:0] shr_q;
                logic [7:0] shr_clr;
                logic [7:0] shr_set;
                assign shr_clr = clr_en    ? clr_mask[g*8 +: 8] : 8'h00;
                assign shr_set = cap_valid ? cap_mask[g*8 +: 8] : 8'h00;
                always_ff @(posedge clk) begin
                    if (!rst_n) shr_q <= 8'h00;
                    else        shr_q <= (shr_q & ~shr_clr) | shr_set;
                end
                assign bank_ns[g*8 +: 8] = shr_q;
                assign bank_s[g*8 +: 8]  = 8'h00;
            end else begin : g_banked
                logic [7:0] s_q, ns_q;
                logic [7:0] s_clr, ns_clr, s_set, ns_set;
                assign s_clr  = (clr_en && clr_secure)     ? clr_mask[g*8 +: 8] : 8'h00;
                assign ns_clr = (clr_en && !clr_secure)    ? clr_mask[g*8 +: 8] : 8'h00;
                assign s_set  = (cap_valid && cap_secure)  ? cap_mask[g*8 +: 8] : 8'h00;
                assign ns_set = (cap_valid && !cap_secure) ? cap_mask[g*8 +: 8] : 8'h00;
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        s_q  <= 8'h00;
                        ns_q <= 8'h00;
                    end else begin
                        s_q  <= (s_q & ~s_clr) | s_set;
                        ns_q <= (ns_q & ~ns_clr) | ns_set;
                    end
                end
                assign bank_s[g*8 +: 8]  = s_q;
                assign bank_ns[g*8 +: 8] = ns_q;
            end
        end
    endgenerate

    // R11: a captured non-secure bit is present the next cycle, even under a clear
    assert_capture_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && !cap_secure) |=> ((bank_ns & $past(cap_mask)) == $past(cap_mask)));

    // R10: with no clear and no capture, both banks hold their value
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_en && !cap_valid) |=> ($stable(bank_s) && $stable(bank_ns)));
endmodule

// File: rtl/fsr_fault_addr.sv
module fsr_fault_addr
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata;
    end
endmodule

// File: rtl/fault_status_banks.sv
module fault_status_banks
    import fsr_pkg::*;
#(
    parameter bit HAS_MAIN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    input  logic [DATA_W-1:0] wdata,
    input  logic              secure,
    input  logic              bf_to_ns,
    input  logic              cap_valid,
    input  logic              cap_secure,
    input  logic [DATA_W-1:0] cap_mask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rdata,
    output logic              rsp_err
);
    localparam logic [DATA_W-1:0] SHARED_BITS = DATA_W'(32'hFF) << (SHARED_LANE * 8);

    logic              hit_status, hit_faddr, bad;
    logic [1:0]        byte_off;
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] bank_s, bank_ns, faddr_q;
    logic              shared_ok;
    logic [DATA_W-1:0] aligned, clr_mask;
    logic              clr_en, faddr_we;
    logic [DATA_W-1:0] word_vis, status_rd, faddr_rd, rsp_d;
    phase_t            phase_q, phase_d;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;

    fsr_decode #(.HAS_MAIN(HAS_MAIN)) u_decode (
        .addr       (addr),
        .size       (size),
        .hit_status (hit_status),
        .hit_faddr  (hit_faddr),
        .bad        (bad),
        .byte_off   (byte_off),
        .lane_mask  (lane_mask)
    );

    assign shared_ok = secure || bf_to_ns;

    always_comb begin
        aligned  = (wdata << {byte_off, 3'b000}) & lane_mask;
        clr_mask = shared_ok ? aligned : (aligned & ~SHARED_BITS);
    end

    assign clr_en   = req && wr && hit_status;
    assign faddr_we = req && wr && hit_faddr && shared_ok;

    fsr_status_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_en     (clr_en),
        .clr_secure (secure),
        .clr_mask   (clr_mask),
        .cap_valid  (cap_valid),
        .cap_secure (cap_secure),
        .cap_mask   (cap_mask),
        .bank_s     (bank_s),
        .bank_ns    (bank_ns)
    );

    fsr_fault_addr u_faddr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (faddr_we),
        .wdata (wdata),
        .q     (faddr_q)
    );

    always_comb begin
        word_vis = secure ? (bank_s & ~SHARED_BITS) : (bank_ns & ~SHARED_BITS);
        if (shared_ok) word_vis = word_vis | (bank_ns & SHARED_BITS);
        status_rd = (word_vis & lane_mask) >> {byte_off, 3'b000};
        faddr_rd  = shared_ok ? faddr_q : '0;
        if (!wr && hit_status)     rsp_d = status_rd;
        else if (!wr && hit_faddr) rsp_d = faddr_rd;
        else                       rsp_d = '0;
    end

    // response phase machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: phase_d = req ? PH_RESP : PH_IDLE;
            PH_RESP: phase_d = req ? PH_RESP : PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    // response phase machine: outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            rdata_q <= req ? rsp_d : '0;
            err_q   <= req && bad;
        end
    end

    assign rsp_valid = (phase_q == PH_RESP);
    assign rdata     = rdata_q;
    assign rsp_err   = err_q;

    // R12: one response per request, in the next cycle
    assert_resp_follows_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_valid);
    assert_quiet_after_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rsp_valid);

    // R3: hidden shared byte reads as zero for non-secure word reads
    assert_hidden_byte_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wr && !secure && !bf_to_ns && addr == STATUS_ADDR && size == 3'd4)
        |=> (rdata[15:8] == 8'h00));

    // R8: a hidden non-secure write leaves the fault address alone
    assert_faddr_hidden_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && wr && !secure && !bf_to_ns && addr == FADDR_ADDR) |=> $stable(faddr_q));

    // R10: an error response carries no data
    assert_err_no_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rdata == '0));
endmodule

// File: tb/fault_status_banks_test.sv
module fault_status_banks_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, wr = 1'b0, secure = 1'b0, bf_to_ns = 1'b0;
    logic [11:0] addr = '0;
    logic [2:0]  size = '0;
    logic [31:0] wdata = '0;
    logic        cap_valid = 1'b0, cap_secure = 1'b0;
    logic [31:0] cap_mask = '0;
    logic        rsp_valid, rsp_err, nm_valid, nm_err;
    logic [31:0] rdata, nm_rdata;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;   // 4 ns period, 250 MHz

    fault_status_banks uut (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .size(size),
        .wdata(wdata), .secure(secure), .bf_to_ns(bf_to_ns), .cap_valid(cap_valid),
        .cap_secure(cap_secure), .cap_mask(cap_mask), .rsp_valid(rsp_valid),
        .rdata(rdata), .rsp_err(rsp_err));

    fault_status_banks #(.HAS_MAIN(1'b0)) uut_nomain (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .size(size),
        .wdata(wdata), .secure(secure), .bf_to_ns(bf_to_ns), .cap_valid(cap_valid),
        .cap_secure(cap_secure), .cap_mask(cap_mask), .rsp_valid(nm_valid),
        .rdata(nm_rdata), .rsp_err(nm_err));

    typedef struct packed {
        logic        wr;
        logic        sec;
        logic        route;
        logic [11:0] addr;
        logic [2:0]  size;
        logic [31:0] wdata;
        logic        exp_err;
        logic [31:0] exp_rdata;
    } vec_t;

    localparam int NVEC = 31;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0,1'b1,1'b0,12'hD28,3'd4,32'h0,1'b0,32'h00A3AB34}, // R2 secure view
        '{1'b0,1'b0,1'b1,12'hD28,3'd4,32'h0,1'b0,32'h0005AB12}, // R2 NS routed view
        '{1'b0,1'b0,1'b0,12'hD28,3'd4,32'h0,1'b0,32'h00050012}, // R3 hidden byte
        '{1'b0,1'b1,1'b0,12'hD29,3'd1,32'h0,1'b0,32'h000000AB}, // R4 byte 1
        '{1'b0,1'b1,1'b0,12'hD2A,3'd2,32'h0,1'b0,32'h000000A3}, // R4 upper half
        '{1'b0,1'b0,1'b1,12'hD29,3'd2,32'h0,1'b0,32'h000005AB}, // R4 unaligned half
        '{1'b0,1'b0,1'b0,12'hD29,3'd1,32'h0,1'b0,32'h00000000}, // R3 hidden byte alone
        '{1'b0,1'b1,1'b0,12'hD2B,3'd2,32'h0,1'b1,32'h00000000}, // R10 overruns word
        '{1'b0,1'b1,1'b0,12'hD2C,3'd1,32'h0,1'b1,32'h00000000}, // R10 unknown address
        '{1'b0,1'b1,1'b0,12'hD28,3'd3,32'h0,1'b1,32'h00000000}, // R10 bad size
        '{1'b1,1'b0,1'b0,12'hD28,3'd4,32'h0000FF00,1'b0,32'h0}, // R6 hidden clear
        '{1'b0,1'b1,1'b0,12'hD28,3'd4,32'h0,1'b0,32'h00A3AB34}, // R6 shared intact
        '{1'b1,1'b0,1'b0,12'hD28,3'd4,32'h00000002,1'b0,32'h0}, // R5 NS clear bit1
        '{1'b0,1'b1,1'b0,12'hD28,3'd4,32'h0,1'b0,32'h00A3AB34}, // R5 other bank kept
        '{1'b0,1'b0,1'b1,12'hD28,3'd4,32'h0,1'b0,32'h0005AB10}, // R5 NS cleared
        '{1'b1,1'b1,1'b0,12'hD29,3'd1,32'h00000003,1'b0,32'h0}, // R7 secure clears shared
        '{1'b0,1'b0,1'b1,12'hD28,3'd4,32'h0,1'b0,32'h0005A810}, // R7 NS sees clear
        '{1'b1,1'b1,1'b0,12'hD2A,3'd1,32'h00000001,1'b0,32'h0}, // R5 secure byte clear
        '{1'b0,1'b1,1'b0,12'hD28,3'd4,32'h0,1'b0,32'h00A2A834}, // R5 secure cleared
        '{1'b1,1'b1,1'b0,12'hD2B,3'd2,32'h0000FFFF,1'b1,32'h0}, // R10 bad write
        '{1'b0,1'b1,1'b0,12'hD28,3'd4,32'h0,1'b0,32'h00A2A834}, // R10 no change
        '{1'b1,1'b1,1'b0,12'hD38,3'd4,32'hDEAD0010,1'b0,32'h0}, // R8 secure write
        '{1'b0,1'b0,1'b0,12'hD38,3'd4,32'h0,1'b0,32'h00000000}, // R8 hidden read
        '{1'b1,1'b0,1'b0,12'hD38,3'd4,32'h11111111,1'b0,32'h0}, // R8 hidden write
        '{1'b0,1'b1,1'b0,12'hD38,3'd4,32'h0,1'b0,32'hDEAD0010}, // R8 value kept
        '{1'b1,1'b0,1'b1,12'hD38,3'd4,32'h22223333,1'b0,32'h0}, // R8 routed write
        '{1'b0,1'b0,1'b1,12'hD38,3'd4,32'h0,1'b0,32'h22223333}, // R8 routed read
        '{1'b0,1'b1,1'b0,12'hD38,3'd2,32'h0,1'b1,32'h00000000}, // R9 wrong size
        '{1'b0,1'b1,1'b0,12'hD3C,3'd4,32'h0,1'b1,32'h00000000}, // R10 unknown address
        '{1'b1,1'b0,1'b1,12'hD29,3'd1,32'h00000080,1'b0,32'h0}, // R5 NS routed clear bit15
        '{1'b0,1'b1,1'b0,12'hD29,3'd1,32'h0,1'b0,32'h00000028}  // R2 secure sees it
    };

    logic [31:0] got_d;
    logic        got_e, got_v;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic s, input logic rt, input logic [11:0] a,
                          input logic [2:0] sz, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; wr = w; secure = s; bf_to_ns = rt; addr = a; size = sz; wdata = d;
        @(negedge clk);
        got_v = rsp_valid; got_d = rdata; got_e = rsp_err;
        req = 1'b0; cap_valid = 1'b0;
    endtask

    task automatic capture(input logic s, input logic [31:0] m);
        @(negedge clk);
        cap_valid = 1'b1; cap_secure = s; cap_mask = m;
        @(negedge clk);
        cap_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
        access(1'b0, 1'b1, 1'b0, 12'hD28, 3'd4, 32'h0);
        check("R1 secure bank", got_d, 32'h0);
        access(1'b0, 1'b0, 1'b1, 12'hD28, 3'd4, 32'h0);
        check("R1 non-secure bank", got_d, 32'h0);
        access(1'b0, 1'b1, 1'b0, 12'hD38, 3'd4, 32'h0);
        check("R1 fault address", got_d, 32'h0);

        capture(1'b0, 32'h0005AB12);
        capture(1'b1, 32'h00A30034);

        for (int i = 0; i < NVEC; i++) begin
            access(VECS[i].wr, VECS[i].sec, VECS[i].route, VECS[i].addr, VECS[i].size,
                   VECS[i].wdata);
            check($sformatf("vector %0d rdata", i), got_d, VECS[i].exp_rdata);
            check($sformatf("vector %0d err", i), {31'b0, got_e}, {31'b0, VECS[i].exp_err});
            check($sformatf("R12 vector %0d valid", i), {31'b0, got_v}, 32'h1);
        end

        @(negedge clk);
        check("R12 valid drops when idle", {31'b0, rsp_valid}, 32'h0);

        // R11: capture and clear of the same bit in one cycle
        @(negedge clk);
        cap_valid = 1'b1; cap_secure = 1'b0; cap_mask = 32'h00000001;
        access(1'b1, 1'b0, 1'b1, 12'hD28, 3'd4, 32'h00000001);
        access(1'b0, 1'b0, 1'b1, 12'hD28, 3'd4, 32'h0);
        check("R11 capture beats clear", got_d, 32'h00052811);

        capture(1'b1, 32'h00004000);
        access(1'b0, 1'b0, 1'b1, 12'hD29, 3'd1, 32'h0);
        check("R11 secure capture into shared byte", got_d, 32'h00000068);
        access(1'b0, 1'b1, 1'b0, 12'hD28, 3'd4, 32'h0);
        check("R11 secure bank view", got_d, 32'h00A26834);

        // R9: no main feature means the fault address does not exist
        access(1'b0, 1'b1, 1'b0, 12'hD38, 3'd4, 32'h0);
        check("R9 main present no error", {31'b0, got_e}, 32'h0);
        check("R9 main absent error", {31'b0, nm_err}, 32'h1);
        check("R9 main absent status ok", nm_rdata, 32'h0);
        access(1'b0, 1'b1, 1'b0, 12'hD28, 3'd4, 32'h0);
        check("R9 main absent status word", nm_rdata, 32'h00A26834);

        // R12: back-to-back requests keep rsp_valid high
        @(negedge clk);
        req = 1'b1; wr = 1'b0; secure = 1'b1; addr = 12'hD28; size = 3'd4;
        @(negedge clk);
        check("R12 first of pair", {31'b0, rsp_valid}, 32'h1);
        @(negedge clk);
        check("R12 second of pair", {31'b0, rsp_valid}, 32'h1);
        req = 1'b0;
        @(negedge clk);
        check("R12 idle after pair", {31'b0, rsp_valid}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule